// File: doc/BRIEF.md
# Register-to-Bus Command Bridge

This block is a slave bridge between a 64-bit register-access port and a simple downstream parallel bus. Software issues one downstream cycle with a single 64-bit command write. The upper half of that write gives the direction, the transfer size and a 24-bit address. The lower half carries the write data.

While the cycle is outstanding, the bridge holds a busy flag and keeps the downstream address, data, size and direction steady. It waits for the slave to acknowledge or to report an error. Software polls a status register for completion. That register also returns the captured read data and the sticky error fields, which are grouped by the layer that raised them. A second, latched copy of the status is taken each time a cycle completes. Writing zero to the live status register clears its error fields.

Top module: `regbus_cmd_bridge`

## Requirements
- R1: A write to register index 0 while idle, with a legal size, starts a downstream cycle on the next clock. Bit 63 set selects a write and clear selects a read. Bits 62:61 carry the size. Bits 55:32 carry the address and bits 31:0 the write data.
- R2: Status bit 48 of the 64-bit status read (index 1) shows busy. Busy clears on the clock after the downstream acknowledge or error is seen.
- R3: A read cycle that ends with acknowledge and no error loads the bus read data into status bits 31:0 and sets read-valid at status bit 49. Starting any new cycle clears read-valid.
- R4: A cycle that ends with the error input high ends the cycle and sets the sticky slave-error bit at status bit 52. Read-valid stays clear.
- R5: Size code 00 is 8-bit, 01 is 16-bit and 11 is 32-bit, and each of these codes is driven on bus_size. Code 10 starts no cycle and sets the sticky bad-size bit at status bit 53.
- R6: A command write that arrives while busy is ignored: the downstream outputs stay unchanged. It sets the sticky overrun bit at status bit 54.
- R7: Pulses on ext_err_a are OR-ed sticky into status bits 47:42. Pulses on ext_err_b are OR-ed sticky into status bits 39:34.
- R8: Writing zero to index 1 clears all error fields (bits 54:52, 47:42 and 39:34). A nonzero write to index 1 changes nothing.
- R9: Index 2 returns the status word, including the read data, as it stood just after the most recent cycle completion. A status clear does not change it.
- R10: After reset the downstream strobe is low and all status bits read zero. Index 3 always reads zero.
- R11: While busy, the downstream address, data, size and direction outputs are held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_idx |
| bus_req | output | 1 | Downstream cycle strobe, high while busy |
| bus_we | output | 1 | Downstream direction, 1 means write |
| bus_size | output | 2 | Downstream size code |
| bus_addr | output | 24 | Downstream address |
| bus_wdata | output | 32 | Downstream write data |
| bus_ack | input | 1 | Downstream acknowledge |
| bus_err | input | 1 | Downstream error |
| bus_rdata | input | 32 | Downstream read data |
| ext_err_a | input | 6 | Error flags from the first master class |
| ext_err_b | input | 6 | Error flags from the second master class |

## Verification
The embedded assertions check the cycle handshake on every clock:
- a legal command starts a cycle carrying the commanded address;
- acknowledge or error ends the cycle;
- the outputs hold steady while busy;
- a bad size or an overrun raises its sticky bit;
- an acknowledged read captures its data;
- a zero status write clears the error fields.

The directed scenarios cover what needs a sequence of register accesses to see:
- the bit positions in the 64-bit status word;
- the latched snapshot surviving a clear;
- a nonzero status write having no effect;
- the per-class sticky error fields;
- the reset and unused-index values.

// File: rtl/regbus_cmd_bridge.sv
module regbus_cmd_bridge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_idx,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        bus_req,
  output logic        bus_we,
  output logic [1:0]  bus_size,
  output logic [23:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic        bus_err,
  input  logic [31:0] bus_rdata,
  input  logic [5:0]  ext_err_a,
  input  logic [5:0]  ext_err_b
);

  localparam logic [1:0] SZ_BAD = 2'b10;

  logic        busy_q, we_q, rvalid_q, e_slv_q, e_size_q, e_ovr_q;
  logic [1:0]  size_q;
  logic [23:0] addr_q;
  logic [31:0] wdata_q, rdata_q;
  logic [5:0]  ea_q, eb_q;
  logic [63:0] snap_q;

  logic        n_busy, n_rvalid, n_slv, n_size, n_ovr;
  logic [31:0] n_rdata;
  logic [5:0]  n_ea, n_eb;
  logic [31:0] stat_w, n_stat;

  wire [1:0] cmd_sz  = reg_wdata[62:61];
  wire cmd_hit  = reg_wr && (reg_idx == 2'd0);
  wire cmd_ok   = cmd_hit && !busy_q && (cmd_sz != SZ_BAD);
  wire cmd_bad  = cmd_hit && !busy_q && (cmd_sz == SZ_BAD);
  wire done     = busy_q && (bus_ack || bus_err);
  wire rd_ok    = done && !bus_err && !we_q;
  wire clr      = reg_wr && (reg_idx == 2'd1) && (reg_wdata == 64'd0);

  function automatic logic [31:0] pack_stat(
    input logic busy, input logic rv, input logic slv, input logic bsz,
    input logic ovr, input logic [5:0] ea, input logic [5:0] eb);
    logic [31:0] s;
    s = 32'd0;
    s[16] = busy;
    s[17] = rv;
    s[20] = slv;
    s[21] = bsz;
    s[22] = ovr;
    s[15:10] = ea;
    s[7:2] = eb;
    return s;
  endfunction

  always_comb begin
    n_busy   = cmd_ok ? 1'b1 : (done ? 1'b0 : busy_q);
    n_rvalid = cmd_ok ? 1'b0 : (rd_ok ? 1'b1 : rvalid_q);
    n_rdata  = rd_ok ? bus_rdata : rdata_q;
    n_slv    = (clr ? 1'b0 : e_slv_q)  | (done && bus_err);
    n_size   = (clr ? 1'b0 : e_size_q) | cmd_bad;
    n_ovr    = (clr ? 1'b0 : e_ovr_q)  | (cmd_hit && busy_q);
    n_ea     = (clr ? 6'd0 : ea_q) | ext_err_a;
    n_eb     = (clr ? 6'd0 : eb_q) | ext_err_b;
    n_stat   = pack_stat(n_busy, n_rvalid, n_slv, n_size, n_ovr, n_ea, n_eb);
  end

  assign stat_w = pack_stat(busy_q, rvalid_q, e_slv_q, e_size_q, e_ovr_q, ea_q, eb_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      we_q     <= 1'b0;
      size_q   <= 2'b00;
      addr_q   <= 24'd0;
      wdata_q  <= 32'd0;
      rvalid_q <= 1'b0;
      rdata_q  <= 32'd0;
      e_slv_q  <= 1'b0;
      e_size_q <= 1'b0;
      e_ovr_q  <= 1'b0;
      ea_q     <= 6'd0;
      eb_q     <= 6'd0;
      snap_q   <= 64'd0;
    end else begin
      if (cmd_ok) begin
        we_q    <= reg_wdata[63];
        size_q  <= cmd_sz;
        addr_q  <= reg_wdata[55:32];
        wdata_q <= reg_wdata[31:0];
      end
      busy_q   <= n_busy;
      rvalid_q <= n_rvalid;
      rdata_q  <= n_rdata;
      e_slv_q  <= n_slv;
      e_size_q <= n_size;
      e_ovr_q  <= n_ovr;
      ea_q     <= n_ea;
      eb_q     <= n_eb;
      if (done) snap_q <= {n_stat, n_rdata};
    end
  end

  assign bus_req   = busy_q;
  assign bus_we    = we_q;
  assign bus_size  = size_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  always_comb begin
    case (reg_idx)
      2'd0:    reg_rdata = {we_q, size_q, 5'd0, addr_q, wdata_q};
      2'd1:    reg_rdata = {stat_w, rdata_q};
      2'd2:    reg_rdata = snap_q;
      default: reg_rdata = 64'd0;
    endcase
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 2'd0 && !bus_req && reg_wdata[62:61] != 2'b10)
    |=> (bus_req && bus_addr == $past(reg_wdata[55:32]) && bus_we == $past(reg_wdata[63])));

  p_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && (bus_ack || bus_err)) |=> !bus_req);

  p_rdcap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_err && !bus_we)
    |=> (stat_w[17] && rdata_q == $past(bus_rdata)));

  p_slverr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_err) |=> (stat_w[20] && !stat_w[17]));

  p_badsize_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 2'd0 && !bus_req && reg_wdata[62:61] == 2'b10)
    |=> (!bus_req && stat_w[21]));

  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 2'd0 && bus_req) |=> stat_w[22]);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 2'd1 && reg_wdata == 64'd0 && !bus_req &&
     ext_err_a == 6'd0 && ext_err_b == 6'd0)
    |=> (stat_w[22:20] == 3'd0 && stat_w[15:10] == 6'd0 && stat_w[7:2] == 6'd0));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err)
    |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_size) && $stable(bus_we)));

endmodule

// File: tb/regbus_cmd_bridge_tb_top.sv
module regbus_cmd_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [63:0] reg_wdata = 64'd0;
  logic [63:0] reg_rdata;
  logic        bus_req, bus_we;
  logic [1:0]  bus_size;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_rdata = 32'd0;
  logic [5:0]  ext_err_a = 6'd0, ext_err_b = 6'd0;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  regbus_cmd_bridge dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic we, input logic [1:0] sz,
                                     input logic [23:0] a, input logic [31:0] d);
    return {we, sz, 5'd0, a, d};
  endfunction

  task automatic wr_reg(input logic [1:0] idx, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 64'd0;
  endtask

  task automatic rd_reg(input logic [1:0] idx, output logic [63:0] d);
    reg_idx = idx;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic respond(input logic ack, input logic err, input logic [31:0] rd);
    @(negedge clk);
    bus_ack = ack; bus_err = err; bus_rdata = rd;
    @(posedge clk);
    @(negedge clk);
    bus_ack = 1'b0; bus_err = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    chk("R10 strobe", {63'd0, bus_req}, 64'd0);
    rd_reg(2'd1, v); chk("R10 status", v, 64'd0);
    rd_reg(2'd2, v); chk("R10 snapshot", v, 64'd0);
    rd_reg(2'd3, v); chk("R10 index3", v, 64'd0);
  endtask

  task automatic t_write32;
    logic [63:0] v;
    wr_reg(2'd0, mk(1'b1, 2'b11, 24'h123456, 32'hDEADBEEF));
    chk("R1 req", {63'd0, bus_req}, 64'd1);
    chk("R1 fields", {bus_we, bus_size, bus_addr, bus_wdata}, {1'b1, 2'b11, 24'h123456, 32'hDEADBEEF});
    rd_reg(2'd1, v); chk("R2 busy set", {63'd0, v[48]}, 64'd1);
    repeat (3) @(negedge clk);
    chk("R11 held", {bus_req, bus_addr, bus_wdata}, {1'b1, 24'h123456, 32'hDEADBEEF});
    respond(1'b1, 1'b0, 32'h0);
    rd_reg(2'd1, v); chk("R2 busy clear", {62'd0, v[49:48]}, 64'd0);
    chk("R2 req low", {63'd0, bus_req}, 64'd0);
  endtask

  task automatic t_read8;
    logic [63:0] v;
    wr_reg(2'd0, mk(1'b0, 2'b00, 24'hFFFFFF, 32'h0));
    chk("R5 size8", {62'd0, bus_size}, 64'd0);
    chk("R1 read dir", {63'd0, bus_we}, 64'd0);
    respond(1'b1, 1'b0, 32'hA5A51234);
    rd_reg(2'd1, v); chk("R3 status", v, {32'h0002_0000, 32'hA5A51234});
    rd_reg(2'd2, v); chk("R9 snap read", v, {32'h0002_0000, 32'hA5A51234});
  endtask

  task automatic t_slave_err;
    logic [63:0] v;
    wr_reg(2'd0, mk(1'b0, 2'b01, 24'h000010, 32'h0));
    chk("R5 size16", {62'd0, bus_size}, 64'd1);
    rd_reg(2'd1, v); chk("R3 rvalid cleared by start", {63'd0, v[49]}, 64'd0);
    respond(1'b0, 1'b1, 32'h55555555);
    rd_reg(2'd1, v); chk("R4 status", v[63:32], 64'h0010_0000);
    chk("R4 rdata kept", v[31:0], 64'hA5A51234);
  endtask

  task automatic t_clear;
    logic [63:0] v;
    wr_reg(2'd1, 64'd1);
    rd_reg(2'd1, v); chk("R8 nonzero ignored", v[63:32], 64'h0010_0000);
    wr_reg(2'd1, 64'd0);
    rd_reg(2'd1, v); chk("R8 cleared", v[63:32], 64'h0);
    rd_reg(2'd2, v); chk("R9 snap kept", v, {32'h0010_0000, 32'hA5A51234});
  endtask

  task automatic t_bad_size;
    logic [63:0] v;
    wr_reg(2'd0, mk(1'b1, 2'b10, 24'h000100, 32'h1));
    chk("R5 no cycle", {63'd0, bus_req}, 64'd0);
    rd_reg(2'd1, v); chk("R5 bad size bit", v[63:32], 64'h0020_0000);
    wr_reg(2'd1, 64'd0);
  endtask

  task automatic t_overrun;
    logic [63:0] v;
    wr_reg(2'd0, mk(1'b1, 2'b11, 24'h00ABCD, 32'h11112222));
    wr_reg(2'd0, mk(1'b0, 2'b00, 24'h999999, 32'h33334444));
    chk("R6 outputs unchanged", {bus_req, bus_we, bus_size, bus_addr, bus_wdata},
        {1'b1, 1'b1, 2'b11, 24'h00ABCD, 32'h11112222});
    rd_reg(2'd1, v); chk("R6 overrun bit", v[63:32], 64'h0041_0000);
    respond(1'b1, 1'b0, 32'h0);
    wr_reg(2'd1, 64'd0);
  endtask

  task automatic t_ext;
    logic [63:0] v;
    @(negedge clk);
    ext_err_a = 6'b101001; ext_err_b = 6'b000110;
    @(posedge clk); @(negedge clk);
    ext_err_a = 6'd0; ext_err_b = 6'd0;
    repeat (2) @(negedge clk);
    rd_reg(2'd1, v);
    chk("R7 class fields", v[63:32], {32'd0, 16'd0, 6'b101001, 2'b00, 6'b000110, 2'b00});
    wr_reg(2'd1, 64'd0);
    rd_reg(2'd1, v); chk("R8 class cleared", v[63:32], 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write32();
    t_read8();
    t_slave_err();
    t_clear();
    t_bad_size();
    t_overrun();
    t_ext();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule